// File: doc/BRIEF.md
# Signed Product Rounder With Selectable Tie Rule

This block takes one full-precision signed product word of `IN_W` bits and reduces it to `OUT_W` bits by rounding to nearest. The low `IN_W-OUT_W` bits are the discarded fraction. The block adds a fixed offset of one half minus one input LSB, plus a single carry bit, and then keeps only the upper `OUT_W` bits.

The carry bit decides what happens when the fraction is exactly one half. One adder therefore serves every tie rule. A two-bit mode input picks the source of the carry:

- an externally supplied dither bit,
- a rule derived from the product's sign, giving ties away from zero or ties toward zero, or
- the lowest kept bit, giving ties to even.

For an unbiased result on average, the dither bit should be a half-duty signal that is not correlated with the fraction, such as a divided clock.

The block handles one real lane. A complex datapath instantiates two of them, one for the real part and one for the imaginary part. A registered output gives one cycle of latency. Valid travels with the data and there is no back-pressure. Overflow at the top of the range wraps and is not saturated. The parameters must satisfy `IN_W > OUT_W >= 2`.

Top module: `prod_round_lane`

## Requirements
- R1: `out_word` is bits `[IN_W-1:IN_W-OUT_W]` of the sum of the sign-extended product, the offset K and the carry bit. K has ones in the lower `IN_W-OUT_W-1` fraction bits and zeros elsewhere. The result therefore equals either the plain truncation of the product or the truncation plus one, taken modulo 2^OUT_W.
- R2: In every mode, a fraction above one half rounds up and a fraction below one half rounds down.
- R3: With `tie_mode` = 2'b00, an exact tie rounds up when `dither_bit` is 1 and down when it is 0. With a toggling dither bit, the mean rounding error over many ties is near zero. With the dither bit held at 0, the mean absolute error over general inputs is still below that of truncation.
- R4: With `tie_mode` = 2'b01, exact ties round away from zero.
- R5: With `tie_mode` = 2'b10, exact ties round toward zero.
- R6: With `tie_mode` = 2'b11, exact ties round to the value whose least significant bit is 0.
- R7: `out_valid` equals `in_valid` of the previous clock. `out_word` changes only in the cycle after an accepted input. When `in_valid` is low, the product, mode and dither inputs have no effect on it.
- R8: During synchronous active-low reset, `out_valid` and `out_word` are 0.
- R9: When rounding up from the most positive truncated value, the result wraps to the most negative code (for 8 bits, 0x7F80 in ties-to-even mode gives 0x80).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Product word is valid this cycle |
| in_prod | input | IN_W | Signed full-precision product |
| tie_mode | input | 2 | Tie rule: 00 dither, 01 away from zero, 10 toward zero, 11 to even |
| dither_bit | input | 1 | External carry used in mode 00 |
| out_valid | output | 1 | Rounded word is valid |
| out_word | output | OUT_W | Signed rounded result |

## Verification
Exact ties of both signs, with both odd and even kept parts, are driven in all four modes. These separate the four tie rules from one another and from a constant carry. Inputs one LSB either side of a tie confirm that the tie rule has no influence off the tie point. A long run of random ties with a toggling dither bit checks that the mean error stays near zero. A run with the dither held low compares the mean absolute error against truncation. Top-of-range inputs exercise wraparound, and idle cycles carrying changing data show that the output holds.

// File: rtl/prod_round_pkg.sv
// Shared types for the product rounding lane.
// Assumes the 2-bit mode encoding below is fixed at the block boundary.
package prod_round_pkg;
    typedef enum logic [1:0] {
        TIE_DITHER = 2'b00,
        TIE_AWAY   = 2'b01,
        TIE_ZERO   = 2'b10,
        TIE_EVEN   = 2'b11
    } tie_mode_e;
endpackage

// File: rtl/prod_round_carry_sel.sv
// Picks the one-bit round carry that settles exact ties.
// Assumes IN_W > OUT_W, so the lowest kept bit sits at index IN_W-OUT_W.
module prod_round_carry_sel
    import prod_round_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0] prod,
    input  tie_mode_e       mode,
    input  logic            dither_bit,
    output logic            carry
);
    localparam int DROP = IN_W - OUT_W;

    // Map the selected tie rule onto a carry value.
    always_comb begin
        case (mode)
            TIE_DITHER: carry = dither_bit;
            TIE_AWAY:   carry = ~prod[IN_W-1];
            TIE_ZERO:   carry = prod[IN_W-1];
            default:    carry = prod[DROP];
        endcase
    end
endmodule

// File: rtl/prod_round_add_trunc.sv
// Adds the just-under-half offset and the carry at IN_W+1 bits, then keeps
// the upper OUT_W bits of the product field. Assumes IN_W > OUT_W >= 2.
module prod_round_add_trunc #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  prod,
    input  logic             carry,
    output logic [OUT_W-1:0] rounded
);
    localparam int DROP = IN_W - OUT_W;
    localparam int SW   = IN_W + 1;

    logic [SW-1:0] ext_w;
    logic [SW-1:0] k_w;
    logic [SW-1:0] cy_w;

    // Offset is zero when only one bit is dropped; the carry supplies the half.
    if (DROP > 1) begin : g_offset
        assign k_w = (SW'(1) << (DROP - 1)) - SW'(1);
    end else begin : g_no_offset
        assign k_w = '0;
    end

    // Sign-extend the product and widen the carry.
    always_comb begin
        ext_w = {prod[IN_W-1], prod};
        cy_w  = {{(SW-1){1'b0}}, carry};
    end

    // Sum at full width and drop the fraction; wraparound is intended.
    assign rounded = OUT_W'((ext_w + k_w + cy_w) >> DROP);
endmodule

// File: rtl/prod_round_out_reg.sv
// Output stage: one cycle of latency, and the data holds while the input is idle.
// Assumes a synchronous active-low reset.
module prod_round_out_reg #(
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OUT_W-1:0] rounded,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_word
);
    // Register valid every cycle; capture data only on accepted inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= rounded;
            end
        end
    end

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r7_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word));
endmodule

// File: rtl/prod_round_lane.sv
// Top of one rounding lane: carry select, offset adder with truncation,
// and the output register. Assumes IN_W > OUT_W >= 2.
module prod_round_lane
    import prod_round_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_prod,
    input  logic [1:0]       tie_mode,
    input  logic             dither_bit,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_word
);
    localparam int DROP = IN_W - OUT_W;
    localparam logic [DROP-1:0] HALF = DROP'(1) << (DROP - 1);

    tie_mode_e        mode_e;
    logic             carry;
    logic [OUT_W-1:0] rounded;

    // Cast the raw mode pins to the shared enum.
    assign mode_e = tie_mode_e'(tie_mode);

    prod_round_carry_sel #(.IN_W(IN_W), .OUT_W(OUT_W)) u_carry (
        .prod       (in_prod),
        .mode       (mode_e),
        .dither_bit (dither_bit),
        .carry      (carry)
    );

    prod_round_add_trunc #(.IN_W(IN_W), .OUT_W(OUT_W)) u_add (
        .prod    (in_prod),
        .carry   (carry),
        .rounded (rounded)
    );

    prod_round_out_reg #(.OUT_W(OUT_W)) u_oreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .rounded   (rounded),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    // R1: the result is the truncation or the truncation plus one.
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((OUT_W'(out_word - $past(in_prod[IN_W-1:DROP])) == OUT_W'(0)) ||
                      (OUT_W'(out_word - $past(in_prod[IN_W-1:DROP])) == OUT_W'(1))));
    // R6: a tie in even mode always leaves an even result.
    a_r6_even_tie: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && tie_mode == 2'b11 && in_prod[DROP-1:0] == HALF) |=> !out_word[0]);
    // R4: a positive tie in away mode rounds up.
    a_r4_away_pos_tie: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && tie_mode == 2'b01 && !in_prod[IN_W-1] && in_prod[DROP-1:0] == HALF)
        |=> out_word == OUT_W'($past(in_prod[IN_W-1:DROP]) + OUT_W'(1)));
    // R5: a positive tie in toward-zero mode truncates.
    a_r5_zero_pos_tie: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && tie_mode == 2'b10 && !in_prod[IN_W-1] && in_prod[DROP-1:0] == HALF)
        |=> out_word == $past(in_prod[IN_W-1:DROP]));
endmodule

// File: tb/test_prod_round_lane.sv
// Bench: a behavioural integer model, compared with the outputs at every falling edge.
module test_prod_round_lane;
    localparam int IN_W  = 16;
    localparam int OUT_W = 8;
    localparam int D     = IN_W - OUT_W;
    localparam int HALFV = 1 << (D - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [IN_W-1:0] in_prod = '0;
    logic [1:0] tie_mode = 2'b00;
    logic dither_bit = 1'b0;
    logic out_valid;
    logic [OUT_W-1:0] out_word;

    int n_vec = 0;
    int n_bad = 0;

    // Expectation set with the stimulus, then moved to "current" at the edge.
    logic pend_v = 1'b0;
    logic [OUT_W-1:0] pend_w = '0;
    string pend_req = "R8";
    int pend_stat = 0;
    int pend_in = 0;
    logic cur_v = 1'b0;
    logic [OUT_W-1:0] cur_w = '0;
    string cur_req = "R8";
    int cur_stat = 0;
    int cur_in = 0;

    longint dith_sum = 0;
    int dith_n = 0;
    longint rnd_abs = 0;
    longint trn_abs = 0;

    always #5 clk = ~clk;

    prod_round_lane #(.IN_W(IN_W), .OUT_W(OUT_W)) i_prod_round_lane (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_prod(in_prod),
        .tie_mode(tie_mode), .dither_bit(dither_bit),
        .out_valid(out_valid), .out_word(out_word)
    );

    // Reference rounding computed from the requirements.
    function automatic int model(int v, int m, bit d);
        int q;
        int rem;
        q = v >>> D;
        rem = v - (q <<< D);
        if (rem > HALFV) return q + 1;
        if (rem < HALFV) return q;
        case (m)
            0: return d ? q + 1 : q;
            1: return (v > 0) ? q + 1 : q;
            2: return (v < 0) ? q + 1 : q;
            default: return q[0] ? q + 1 : q;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            cur_v = 1'b0; cur_w = '0; cur_req = "R8"; cur_stat = 0;
        end else begin
            cur_v = pend_v;
            if (pend_v) cur_w = pend_w;
            cur_req = pend_v ? pend_req : "R7";
            cur_stat = pend_v ? pend_stat : 0;
            cur_in = pend_in;
        end
    end

    always @(negedge clk) begin
        n_vec++;
        if (out_valid !== cur_v || out_word !== cur_w) begin
            n_bad++;
            $display("FAIL %s: valid=%0b word=%h expected valid=%0b word=%h",
                     cur_req, out_valid, out_word, cur_v, cur_w);
        end
        if (cur_v && cur_stat == 1) begin
            dith_sum += longint'($signed(out_word)) * (1 << D) - cur_in;
            dith_n++;
        end
        if (cur_v && cur_stat == 2) begin
            longint e;
            e = longint'($signed(out_word)) * (1 << D) - cur_in;
            rnd_abs += (e < 0) ? -e : e;
            trn_abs += cur_in - ((cur_in >>> D) <<< D);
        end
    end

    task automatic put(int v, int m, bit d, string req, int stat = 0);
        int r;
        @(negedge clk);
        in_valid = 1'b1;
        in_prod = v[IN_W-1:0];
        tie_mode = m[1:0];
        dither_bit = d;
        r = model(v, m, d);
        pend_v = 1'b1; pend_w = r[OUT_W-1:0]; pend_req = req;
        pend_stat = stat; pend_in = v;
    endtask

    task automatic idle(int v);
        @(negedge clk);
        in_valid = 1'b0;
        in_prod = v[IN_W-1:0];
        tie_mode = v[1:0];
        dither_bit = v[2];
        pend_v = 1'b0; pend_stat = 0;
    endtask

    task automatic stat_check(bit ok, string req, string what, longint act, longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        bit tog;
        // R8: outputs stay zero during reset.
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // Exact ties of both signs, odd and even kept parts, in all modes (R3..R6).
        for (int m = 0; m < 4; m++) begin
            for (int q = -4; q <= 4; q++) begin
                for (int d = 0; d < 2; d++) begin
                    string rq;
                    rq = (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R6";
                    put((q <<< D) + HALFV, m, d[0], rq);
                    // R2: one LSB either side of the tie.
                    put((q <<< D) + HALFV + 1, m, d[0], "R2");
                    put((q <<< D) + HALFV - 1, m, d[0], "R2");
                end
            end
        end
        // R9: wraparound at the top of the range.
        put(16'h7F80, 3, 1'b0, "R9");
        put(16'h7FFF, 0, 1'b0, "R9");
        put(16'h7F80, 1, 1'b0, "R9");
        // R7: idle cycles with changing inputs must not move the output.
        put(16'h0123, 2, 1'b0, "R7");
        for (int i = 0; i < 6; i++) idle(int'($urandom));
        put(-300, 1, 1'b1, "R7");
        put(77, 3, 1'b0, "R7");
        idle(16'h5555);
        // R1: random words in every mode, with gaps.
        for (int i = 0; i < 4000; i++) begin
            int v;
            v = int'($urandom) & 16'hFFFF;
            v = (v >= 32768) ? v - 65536 : v;
            if ($urandom % 8 == 0) idle(v);
            else put(v, int'($urandom % 4), bit'($urandom % 2), "R1");
        end
        // R3: dithered ties using a toggling carry source.
        tog = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            int q;
            q = int'($urandom % 200) - 100;
            put((q <<< D) + HALFV, 0, tog, "R3", 1);
            tog = ~tog;
        end
        // R3: carry held low against truncation on general inputs.
        for (int i = 0; i < 3000; i++) begin
            int v;
            v = int'($urandom % 32768) - 16384;
            put(v, 0, 1'b0, "R3", 2);
        end
        idle(0);
        @(negedge clk);
        @(negedge clk);
        stat_check((dith_n > 0) && (dith_sum * 16 < longint'(dith_n) * HALFV) &&
                   (-dith_sum * 16 < longint'(dith_n) * HALFV),
                   "R3", "dithered error sum", dith_sum, 0);
        stat_check(rnd_abs < trn_abs, "R3", "rounded abs error vs truncation",
                   rnd_abs, trn_abs);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule